// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block is the multi-cycle control unit of an 8-bit processor core that handles every instruction that moves the 16-bit program counter or the 16-bit stack pointer. It covers direct calls, calls into a fixed 2 KB page, and calls through a vector table. It also handles a software break, plain, interrupt and break returns, pushes and pops of the status byte and of 16-bit register pairs, loads and reads of the stack pointer, direct, relative and register-indirect jumps, and flag-conditional relative branches. The stack pointer lives inside the block.

A decoder presents a decoded operation with its operand fields, the current PC, the status byte and a register pair, and pulses `start` while the block is idle. The block captures these inputs and runs the operation over its fixed cycle count. It uses a byte-wide data memory port for stack and vector traffic. It then pulses `done` together with write-enable strobes for the PC, the status byte and the register pair. The data memory returns read data one cycle after a read request.

Top module: `cs_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `mem_we`, `mem_re` and every write strobe are 0, and `sp_o` equals the SP_INIT parameter.
- R2: `busy` stays high for exactly the operation's cycle count. Counts: absolute call 7, page call 5, vector call 6, break 6, each return 6, status push/pop 2, pair push/pop 4, immediate SP load 10, SP load from pair or SP read 8, absolute jump 6, relative jump 6, register jump 8, conditional branch 6 (taken or not). `done` pulses in the first cycle after `busy` falls, and results and strobes are valid in that cycle.
- R3: An absolute call writes the high byte of PC+3 to SP−1 and then the low byte to SP−2. It loads the PC from the 16-bit operand and lowers SP by 2.
- R4: A page call pushes PC+2 in the same way and sets the PC to {5'b00001, operand[10:0]}.
- R5: A vector call pushes PC+1. It then reads the new PC low byte at address {11'b0, sel} and the high byte at the next address, where sel is operand[4:0]. SP drops by 2.
- R6: A break writes the status byte to SP−1, the PC+1 high byte to SP−2 and the PC+1 low byte to SP−3. It reads the new PC low/high bytes at BRK_VEC and BRK_VEC+1 (default 003EH/003FH) and lowers SP by 3. It outputs the status byte with bit 7 (interrupt enable) cleared.
- R7: A return loads the PC low byte from (SP) and the high byte from (SP+1), then raises SP by 2. The interrupt return and the break return also load the whole status byte from (SP+2) and raise SP by 3. Only the interrupt return pulses `nmi_clr`.
- R8: A status push writes to SP−1 and lowers SP by 1. A pair push writes the high byte to SP−1 and the low byte to SP−2. A status pop reads (SP) and raises SP by 1. A pair pop takes its low byte from (SP) and its high byte from (SP+1) and raises SP by 2.
- R9: The immediate SP load sets SP to the operand. The pair SP load sets SP to `rp_i`. The SP read returns SP on `rp_o` with `rp_we`. None of these three pulses `pc_we`.
- R10: An absolute jump loads the PC from the operand. The register jump loads the PC from `rp_i` (A in the high byte, X in the low byte).
- R11: A relative jump sets the PC to PC+2+sign-extended displacement, modulo 2^16. A conditional branch does the same when its condition holds and otherwise sets the PC to PC+2. The 2-bit condition codes are 0: CY=1, 1: CY=0, 2: Z=1, 3: Z=0, with CY at status bit 0 and Z at status bit 6.
- R12: `start` is ignored while `busy` is high, and `sp_o` changes only at the edge that raises `done`.
- R13: At most one memory access is made per cycle, never a read and a write together, and only while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch the presented operation (taken only when idle) |
| op_i | input | 5 | Decoded operation code (package enum) |
| cond_i | input | 2 | Branch condition code |
| imm_i | input | 16 | Address or word operand |
| disp_i | input | 8 | Signed relative displacement |
| pc_i | input | 16 | Address of the current instruction |
| psw_i | input | 8 | Current status byte |
| rp_i | input | 16 | Register pair value (AX for SP load and register jump) |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 8 | Data memory write byte |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| pc_o | output | 16 | New program counter |
| pc_we | output | 1 | `pc_o` valid for loading |
| psw_o | output | 8 | New status byte |
| psw_we | output | 1 | `psw_o` valid for loading |
| rp_o | output | 16 | Popped pair or SP read value |
| rp_we | output | 1 | `rp_o` valid for loading |
| sp_o | output | 16 | Current stack pointer |
| nmi_clr | output | 1 | Clear the non-maskable-interrupt in-service flag |

## Verification
The jump and branch paths are tried with small forward and backward displacements, with the most negative displacement from a low PC, and with a positive displacement from a high PC. These patterns separate correct sign extension from zero extension and show wrap-around at both ends of the address space. Every condition code is run once with its flag set and once with it clear, which exposes swapped codes or a wrong flag bit. Nested calls, a vector call and two breaks each unwind through the matching return. This confirms byte order on the stack, the order of the break's three writes, status restore, and that only the interrupt return raises `nmi_clr`. A second `start` issued mid-operation shows that a busy sequencer drops it.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;

    typedef enum logic [4:0] {
        OP_NOP       = 5'd0,
        OP_CALL_ABS  = 5'd1,
        OP_CALL_PAGE = 5'd2,
        OP_CALL_VEC  = 5'd3,
        OP_BREAK     = 5'd4,
        OP_RET       = 5'd5,
        OP_RET_INT   = 5'd6,
        OP_RET_BRK   = 5'd7,
        OP_PUSH_ST   = 5'd8,
        OP_PUSH_PR   = 5'd9,
        OP_POP_ST    = 5'd10,
        OP_POP_PR    = 5'd11,
        OP_SP_IMM    = 5'd12,
        OP_SP_AX     = 5'd13,
        OP_SP_RD     = 5'd14,
        OP_JMP_ABS   = 5'd15,
        OP_JMP_REL   = 5'd16,
        OP_JMP_REG   = 5'd17,
        OP_BR_COND   = 5'd18
    } op_e;

    typedef enum logic [1:0] {ACC_NONE, ACC_WR, ACC_RD} acc_e;

    localparam int PSW_IE = 7;
    localparam int PSW_Z  = 6;
    localparam int PSW_CY = 0;

    typedef struct packed {
        op_e         op;
        logic [1:0]  cond;
        logic [15:0] imm;
        logic [7:0]  disp;
        logic [15:0] pc;
        logic [7:0]  psw;
        logic [15:0] rp;
    } cmd_t;

    typedef struct packed {
        logic [15:0] pc;
        logic        pc_we;
        logic [7:0]  psw;
        logic        psw_we;
        logic [15:0] rp;
        logic        rp_we;
        logic [15:0] sp;
        logic        nmi_clr;
    } res_t;

endpackage

// File: rtl/cs_len.sv
`timescale 1ns/1ps
module cs_len
    import cs_pkg::*;
#(
    parameter int W = 4
) (
    input  op_e          op,
    output logic [W-1:0] ncyc
);
    always_comb begin
        unique case (op)
            OP_CALL_ABS:                    ncyc = W'(7);
            OP_CALL_PAGE:                   ncyc = W'(5);
            OP_CALL_VEC, OP_BREAK:          ncyc = W'(6);
            OP_RET, OP_RET_INT, OP_RET_BRK: ncyc = W'(6);
            OP_PUSH_ST, OP_POP_ST:          ncyc = W'(2);
            OP_PUSH_PR, OP_POP_PR:          ncyc = W'(4);
            OP_SP_IMM:                      ncyc = W'(10);
            OP_SP_AX, OP_SP_RD, OP_JMP_REG: ncyc = W'(8);
            OP_JMP_ABS, OP_JMP_REL,
            OP_BR_COND:                     ncyc = W'(6);
            default:                        ncyc = W'(1);
        endcase
    end
endmodule

// File: rtl/cs_access.sv
`timescale 1ns/1ps
module cs_access
    import cs_pkg::*;
#(
    parameter int          W       = 4,
    parameter logic [15:0] BRK_VEC = 16'h003E
) (
    input  op_e          op,
    input  logic [15:0]  pc,
    input  logic [7:0]   psw,
    input  logic [15:0]  rp,
    input  logic [4:0]   vsel,
    input  logic [15:0]  sp,
    input  logic [W-1:0] step,
    output acc_e         kind,
    output logic [15:0]  addr,
    output logic [7:0]   wdata
);
    logic [15:0] ret_pc;
    logic [15:0] vec_a;

    always_comb begin
        unique case (op)
            OP_CALL_ABS:  ret_pc = pc + 16'd3;
            OP_CALL_PAGE: ret_pc = pc + 16'd2;
            default:      ret_pc = pc + 16'd1;
        endcase
        vec_a = {11'd0, vsel};
        kind  = ACC_NONE;
        addr  = '0;
        wdata = '0;
        unique case (op)
            OP_CALL_ABS, OP_CALL_PAGE, OP_CALL_VEC: begin
                case (int'(step))
                    0: begin kind = ACC_WR; addr = sp - 16'd1; wdata = ret_pc[15:8]; end
                    1: begin kind = ACC_WR; addr = sp - 16'd2; wdata = ret_pc[7:0];  end
                    2: if (op == OP_CALL_VEC) begin kind = ACC_RD; addr = vec_a;          end
                    3: if (op == OP_CALL_VEC) begin kind = ACC_RD; addr = vec_a + 16'd1;  end
                    default: ;
                endcase
            end
            OP_BREAK: begin
                case (int'(step))
                    0: begin kind = ACC_WR; addr = sp - 16'd1; wdata = psw;          end
                    1: begin kind = ACC_WR; addr = sp - 16'd2; wdata = ret_pc[15:8]; end
                    2: begin kind = ACC_WR; addr = sp - 16'd3; wdata = ret_pc[7:0];  end
                    3: begin kind = ACC_RD; addr = BRK_VEC;                          end
                    4: begin kind = ACC_RD; addr = BRK_VEC + 16'd1;                  end
                    default: ;
                endcase
            end
            OP_RET, OP_RET_INT, OP_RET_BRK, OP_POP_PR, OP_POP_ST: begin
                case (int'(step))
                    0: begin kind = ACC_RD; addr = sp; end
                    1: if (op != OP_POP_ST) begin kind = ACC_RD; addr = sp + 16'd1; end
                    2: if (op == OP_RET_INT || op == OP_RET_BRK) begin
                           kind = ACC_RD; addr = sp + 16'd2;
                       end
                    default: ;
                endcase
            end
            OP_PUSH_ST: begin
                if (step == '0) begin kind = ACC_WR; addr = sp - 16'd1; wdata = psw; end
            end
            OP_PUSH_PR: begin
                case (int'(step))
                    0: begin kind = ACC_WR; addr = sp - 16'd1; wdata = rp[15:8]; end
                    1: begin kind = ACC_WR; addr = sp - 16'd2; wdata = rp[7:0];  end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cs_target.sv
`timescale 1ns/1ps
module cs_target
    import cs_pkg::*;
(
    input  op_e             op,
    input  logic [1:0]      cond,
    input  logic [15:0]     imm,
    input  logic [7:0]      disp,
    input  logic [15:0]     pc,
    input  logic [7:0]      psw,
    input  logic [15:0]     rp,
    input  logic [15:0]     sp,
    input  logic [2:0][7:0] rbuf,
    output res_t            res
);
    logic [15:0] rel_pc;
    logic [15:0] rd_pc;
    logic        taken;

    always_comb begin
        rel_pc = pc + 16'd2 + {{8{disp[7]}}, disp};
        rd_pc  = {rbuf[1], rbuf[0]};
        unique case (cond)
            2'd0: taken =  psw[PSW_CY];
            2'd1: taken = !psw[PSW_CY];
            2'd2: taken =  psw[PSW_Z];
            default: taken = !psw[PSW_Z];
        endcase
        res = '{pc: pc, pc_we: 1'b0, psw: psw, psw_we: 1'b0,
                rp: rp, rp_we: 1'b0, sp: sp, nmi_clr: 1'b0};
        unique case (op)
            OP_CALL_ABS:  begin res.pc = imm; res.pc_we = 1'b1; res.sp = sp - 16'd2; end
            OP_CALL_PAGE: begin res.pc = {5'b00001, imm[10:0]}; res.pc_we = 1'b1; res.sp = sp - 16'd2; end
            OP_CALL_VEC:  begin res.pc = rd_pc; res.pc_we = 1'b1; res.sp = sp - 16'd2; end
            OP_BREAK: begin
                res.pc = rd_pc; res.pc_we = 1'b1;
                res.psw = psw & ~(8'h01 << PSW_IE); res.psw_we = 1'b1;
                res.sp = sp - 16'd3;
            end
            OP_RET:       begin res.pc = rd_pc; res.pc_we = 1'b1; res.sp = sp + 16'd2; end
            OP_RET_INT, OP_RET_BRK: begin
                res.pc = rd_pc; res.pc_we = 1'b1;
                res.psw = rbuf[2]; res.psw_we = 1'b1;
                res.sp = sp + 16'd3;
                res.nmi_clr = (op == OP_RET_INT);
            end
            OP_PUSH_ST:   res.sp = sp - 16'd1;
            OP_PUSH_PR:   res.sp = sp - 16'd2;
            OP_POP_ST:    begin res.psw = rbuf[0]; res.psw_we = 1'b1; res.sp = sp + 16'd1; end
            OP_POP_PR:    begin res.rp = rd_pc; res.rp_we = 1'b1; res.sp = sp + 16'd2; end
            OP_SP_IMM:    res.sp = imm;
            OP_SP_AX:     res.sp = rp;
            OP_SP_RD:     begin res.rp = sp; res.rp_we = 1'b1; end
            OP_JMP_ABS:   begin res.pc = imm; res.pc_we = 1'b1; end
            OP_JMP_REL:   begin res.pc = rel_pc; res.pc_we = 1'b1; end
            OP_JMP_REG:   begin res.pc = rp; res.pc_we = 1'b1; end
            OP_BR_COND:   begin res.pc = taken ? rel_pc : pc + 16'd2; res.pc_we = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/cs_sequencer.sv
`timescale 1ns/1ps
module cs_sequencer
    import cs_pkg::*;
#(
    parameter logic [15:0] SP_INIT = 16'hFEE0,
    parameter logic [15:0] BRK_VEC = 16'h003E,
    parameter int          STEP_W  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  op_i,
    input  logic [1:0]  cond_i,
    input  logic [15:0] imm_i,
    input  logic [7:0]  disp_i,
    input  logic [15:0] pc_i,
    input  logic [7:0]  psw_i,
    input  logic [15:0] rp_i,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    output logic [15:0] pc_o,
    output logic        pc_we,
    output logic [7:0]  psw_o,
    output logic        psw_we,
    output logic [15:0] rp_o,
    output logic        rp_we,
    output logic [15:0] sp_o,
    output logic        nmi_clr
);
    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
        cmd_t              cmd;
        logic [1:0]        ridx;
        logic              rpend;
        logic [2:0][7:0]   rbuf;
        logic [15:0]       sp;
        logic [15:0]       pc;
        logic              pc_we;
        logic [7:0]        psw;
        logic              psw_we;
        logic [15:0]       rp;
        logic              rp_we;
        logic              nmi_clr;
        logic              done;
    } st_t;

    st_t               st_d, st_q;
    logic [STEP_W-1:0] ncyc;
    acc_e              acc_kind;
    logic [15:0]       acc_addr;
    logic [7:0]        acc_wdata;
    logic [2:0][7:0]   rbuf_nx;
    res_t              res;

    cs_len #(.W(STEP_W)) u_len (.op(st_q.cmd.op), .ncyc(ncyc));

    cs_access #(.W(STEP_W), .BRK_VEC(BRK_VEC)) u_access (
        .op(st_q.cmd.op), .pc(st_q.cmd.pc), .psw(st_q.cmd.psw), .rp(st_q.cmd.rp),
        .vsel(st_q.cmd.imm[4:0]), .sp(st_q.sp), .step(st_q.step),
        .kind(acc_kind), .addr(acc_addr), .wdata(acc_wdata)
    );

    // capture the byte returned for the read issued in the previous cycle
    always_comb begin
        rbuf_nx = st_q.rbuf;
        if (st_q.rpend) rbuf_nx[st_q.ridx] = mem_rdata;
    end

    cs_target u_target (
        .op(st_q.cmd.op), .cond(st_q.cmd.cond), .imm(st_q.cmd.imm), .disp(st_q.cmd.disp),
        .pc(st_q.cmd.pc), .psw(st_q.cmd.psw), .rp(st_q.cmd.rp), .sp(st_q.sp),
        .rbuf(rbuf_nx), .res(res)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pc_we   = 1'b0;
        st_d.psw_we  = 1'b0;
        st_d.rp_we   = 1'b0;
        st_d.nmi_clr = 1'b0;
        st_d.done    = 1'b0;
        st_d.rbuf    = rbuf_nx;
        st_d.rpend   = st_q.run && (acc_kind == ACC_RD);
        if (!st_q.run) begin
            if (start) begin
                st_d.run  = 1'b1;
                st_d.step = '0;
                st_d.ridx = '0;
                st_d.cmd  = '{op: op_e'(op_i), cond: cond_i, imm: imm_i, disp: disp_i,
                              pc: pc_i, psw: psw_i, rp: rp_i};
            end
        end else begin
            if (st_q.rpend) st_d.ridx = st_q.ridx + 2'd1;
            if (st_q.step == ncyc - STEP_W'(1)) begin
                st_d.run     = 1'b0;
                st_d.done    = 1'b1;
                st_d.sp      = res.sp;
                st_d.pc_we   = res.pc_we;
                st_d.psw_we  = res.psw_we;
                st_d.rp_we   = res.rp_we;
                st_d.nmi_clr = res.nmi_clr;
                if (res.pc_we)  st_d.pc  = res.pc;
                if (res.psw_we) st_d.psw = res.psw;
                if (res.rp_we)  st_d.rp  = res.rp;
            end else begin
                st_d.step = st_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.sp <= SP_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.run;
    assign done      = st_q.done;
    assign mem_we    = st_q.run && (acc_kind == ACC_WR);
    assign mem_re    = st_q.run && (acc_kind == ACC_RD);
    assign mem_addr  = acc_addr;
    assign mem_wdata = acc_wdata;
    assign pc_o      = st_q.pc;
    assign pc_we     = st_q.pc_we;
    assign psw_o     = st_q.psw;
    assign psw_we    = st_q.psw_we;
    assign rp_o      = st_q.rp;
    assign rp_we     = st_q.rp_we;
    assign sp_o      = st_q.sp;
    assign nmi_clr   = st_q.nmi_clr;

    // independent count of busy cycles for the length check
    logic [STEP_W-1:0] chk_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    chk_cnt <= '0;
        else if (busy) chk_cnt <= chk_cnt + STEP_W'(1);
        else           chk_cnt <= '0;
    end

    // R13
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R13
    mem_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy);

    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_cnt == ncyc));

    // R12
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(sp_o));

    // R12
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done));

endmodule

// File: tb/test_cs_sequencer.sv
`timescale 1ns/1ps
module test_cs_sequencer;
    import cs_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  op_i = '0;
    logic [1:0]  cond_i = '0;
    logic [15:0] imm_i = '0;
    logic [7:0]  disp_i = '0;
    logic [15:0] pc_i = '0;
    logic [7:0]  psw_i = '0;
    logic [15:0] rp_i = '0;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done, mem_we, mem_re, pc_we, psw_we, rp_we, nmi_clr;
    logic [15:0] mem_addr, pc_o, rp_o, sp_o;
    logic [7:0]  mem_wdata, psw_o;

    always #2.5 clk = ~clk;

    cs_sequencer i_cs_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .cond_i(cond_i),
        .imm_i(imm_i), .disp_i(disp_i), .pc_i(pc_i), .psw_i(psw_i), .rp_i(rp_i),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .pc_o(pc_o),
        .pc_we(pc_we), .psw_o(psw_o), .psw_we(psw_we), .rp_o(rp_o), .rp_we(rp_we),
        .sp_o(sp_o), .nmi_clr(nmi_clr)
    );

    // data memory model: registered read, one-cycle latency
    logic [7:0] mem [1024];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    end

    // write log sampled mid-cycle
    int          wl_n = 0;
    logic [15:0] wl_a [8];
    logic [7:0]  wl_d [8];
    always @(negedge clk) begin
        if (mem_we && wl_n < 8) begin
            wl_a[wl_n] = mem_addr;
            wl_d[wl_n] = mem_wdata;
            wl_n++;
        end
    end

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input op_e op, input logic [1:0] c, input logic [15:0] imm,
                          input logic [7:0] disp, input logic [15:0] pc,
                          input logic [7:0] psw, input logic [15:0] rp, output int cyc);
        @(negedge clk);
        wl_n   = 0;
        op_i   = op;  cond_i = c;  imm_i = imm; disp_i = disp;
        pc_i   = pc;  psw_i  = psw; rp_i = rp;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 40) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        op_e         op;
        logic [1:0]  cond;
        logic [15:0] imm;
        logic [7:0]  disp;
        logic [15:0] pc;
        logic [7:0]  psw;
        logic [15:0] rp;
        logic [7:0]  cyc;
        logic        pcwe;
        logic [15:0] epc;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{OP_JMP_ABS, 2'd0, 16'h1234, 8'h00, 16'h0100, 8'h00, 16'h0000, 8'd6,  1'b1, 16'h1234},
        '{OP_JMP_REL, 2'd0, 16'h0000, 8'h05, 16'h0100, 8'h00, 16'h0000, 8'd6,  1'b1, 16'h0107},
        '{OP_JMP_REL, 2'd0, 16'h0000, 8'hFE, 16'h0100, 8'h00, 16'h0000, 8'd6,  1'b1, 16'h0100},
        '{OP_JMP_REL, 2'd0, 16'h0000, 8'h80, 16'h0010, 8'h00, 16'h0000, 8'd6,  1'b1, 16'hFF92},
        '{OP_JMP_REL, 2'd0, 16'h0000, 8'h7F, 16'hFFF0, 8'h00, 16'h0000, 8'd6,  1'b1, 16'h0071},
        '{OP_JMP_REG, 2'd0, 16'h0000, 8'h00, 16'h0100, 8'h00, 16'hABCD, 8'd8,  1'b1, 16'hABCD},
        '{OP_BR_COND, 2'd0, 16'h0000, 8'h10, 16'h0200, 8'h01, 16'h0000, 8'd6,  1'b1, 16'h0212},
        '{OP_BR_COND, 2'd0, 16'h0000, 8'h10, 16'h0200, 8'h00, 16'h0000, 8'd6,  1'b1, 16'h0202},
        '{OP_BR_COND, 2'd1, 16'h0000, 8'hF0, 16'h0200, 8'h00, 16'h0000, 8'd6,  1'b1, 16'h01F2},
        '{OP_BR_COND, 2'd2, 16'h0000, 8'h20, 16'h0300, 8'h40, 16'h0000, 8'd6,  1'b1, 16'h0322},
        '{OP_BR_COND, 2'd3, 16'h0000, 8'h20, 16'h0300, 8'h40, 16'h0000, 8'd6,  1'b1, 16'h0302},
        '{OP_BR_COND, 2'd3, 16'h0000, 8'h04, 16'h0300, 8'h00, 16'h0000, 8'd6,  1'b1, 16'h0306},
        '{OP_SP_AX,   2'd0, 16'h0000, 8'h00, 16'h0000, 8'h00, 16'h0280, 8'd8,  1'b0, 16'h0000},
        '{OP_SP_IMM,  2'd0, 16'h0300, 8'h00, 16'h0000, 8'h00, 16'h0000, 8'd10, 1'b0, 16'h0000},
        '{OP_SP_RD,   2'd0, 16'h0000, 8'h00, 16'h0000, 8'h00, 16'h0000, 8'd8,  1'b0, 16'h0000}
    };

    function automatic string tag_of(input op_e op);
        case (op)
            OP_JMP_ABS, OP_JMP_REG: return "R10";
            OP_JMP_REL, OP_BR_COND: return "R11";
            default:                return "R9";
        endcase
    endfunction

    initial begin
        #(5ns * 20000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        if (!finished) begin
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        mem[5]  = 8'h34; mem[6]  = 8'h12;   // vector slot 5
        mem[62] = 8'h78; mem[63] = 8'h56;   // break vector 003E/003F
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem strobes", {mem_we, mem_re}, 0);
        chk("R1 strobes", {pc_we, psw_we, rp_we, nmi_clr}, 0);
        chk("R1 sp", sp_o, 16'hFEE0);

        for (int i = 0; i < NV; i++) begin
            run_op(VT[i].op, VT[i].cond, VT[i].imm, VT[i].disp, VT[i].pc, VT[i].psw, VT[i].rp, cyc);
            chk({"R2 cycles ", tag_of(VT[i].op)}, cyc, VT[i].cyc);
            chk("R2 done", done, 1);
            chk({tag_of(VT[i].op), " pc_we"}, pc_we, VT[i].pcwe);
            if (VT[i].pcwe) chk({tag_of(VT[i].op), " pc"}, pc_o, VT[i].epc);
        end
        chk("R9 sp after immediate load", sp_o, 16'h0300);

        run_op(OP_SP_IMM, 0, 16'h0200, 0, 0, 0, 0, cyc);
        chk("R9 sp load", sp_o, 16'h0200);

        // R3 absolute call
        run_op(OP_CALL_ABS, 0, 16'h4000, 0, 16'h1000, 0, 0, cyc);
        chk("R3 cycles", cyc, 7);
        chk("R3 writes", wl_n, 2);
        chk("R3 wr0", {wl_a[0], wl_d[0]}, {16'h01FF, 8'h10});
        chk("R3 wr1", {wl_a[1], wl_d[1]}, {16'h01FE, 8'h03});
        chk("R3 pc", {pc_we, pc_o}, {1'b1, 16'h4000});
        chk("R3 sp", sp_o, 16'h01FE);

        // R4 page call
        run_op(OP_CALL_PAGE, 0, 16'hFFFF, 0, 16'h1234, 0, 0, cyc);
        chk("R4 cycles", cyc, 5);
        chk("R4 wr", {wl_a[0], wl_d[0], wl_a[1], wl_d[1]}, {16'h01FD, 8'h12, 16'h01FC, 8'h36});
        chk("R4 pc", pc_o, 16'h0FFF);
        chk("R4 sp", sp_o, 16'h01FC);

        // R7 plain returns unwind both calls
        run_op(OP_RET, 0, 0, 0, 0, 0, 0, cyc);
        chk("R7 cycles", cyc, 6);
        chk("R7 pc", {pc_we, pc_o}, {1'b1, 16'h1236});
        chk("R7 sp", sp_o, 16'h01FE);
        chk("R7 no status", {psw_we, nmi_clr, wl_n[3:0]}, 0);
        run_op(OP_RET, 0, 0, 0, 0, 0, 0, cyc);
        chk("R7 pc second", pc_o, 16'h1003);
        chk("R7 sp second", sp_o, 16'h0200);

        // R5 vector call
        run_op(OP_CALL_VEC, 0, 16'h0005, 0, 16'h2000, 0, 0, cyc);
        chk("R5 cycles", cyc, 6);
        chk("R5 wr", {wl_a[0], wl_d[0], wl_a[1], wl_d[1]}, {16'h01FF, 8'h20, 16'h01FE, 8'h01});
        chk("R5 pc", pc_o, 16'h1234);
        chk("R5 sp", sp_o, 16'h01FE);

        // R6 break
        run_op(OP_BREAK, 0, 0, 0, 16'h3000, 8'hC1, 0, cyc);
        chk("R6 cycles", cyc, 6);
        chk("R6 writes", wl_n, 3);
        chk("R6 wr0", {wl_a[0], wl_d[0]}, {16'h01FD, 8'hC1});
        chk("R6 wr1", {wl_a[1], wl_d[1]}, {16'h01FC, 8'h30});
        chk("R6 wr2", {wl_a[2], wl_d[2]}, {16'h01FB, 8'h01});
        chk("R6 pc", pc_o, 16'h5678);
        chk("R6 psw", {psw_we, psw_o}, {1'b1, 8'h41});
        chk("R6 sp", sp_o, 16'h01FB);

        // R7 interrupt return
        run_op(OP_RET_INT, 0, 0, 0, 0, 0, 0, cyc);
        chk("R7 int cycles", cyc, 6);
        chk("R7 int pc", pc_o, 16'h3001);
        chk("R7 int psw", {psw_we, psw_o}, {1'b1, 8'hC1});
        chk("R7 int nmi_clr", nmi_clr, 1);
        chk("R7 int sp", sp_o, 16'h01FE);
        run_op(OP_RET, 0, 0, 0, 0, 0, 0, cyc);
        chk("R7 pc after vector call", pc_o, 16'h2001);

        // R6 second break, R7 break return
        run_op(OP_BREAK, 0, 0, 0, 16'h0AAA, 8'h85, 0, cyc);
        chk("R6 psw IE clear", psw_o, 8'h05);
        chk("R6 wr2 low", {wl_a[2], wl_d[2]}, {16'h01FD, 8'hAB});
        run_op(OP_RET_BRK, 0, 0, 0, 0, 0, 0, cyc);
        chk("R7 brk pc", pc_o, 16'h0AAB);
        chk("R7 brk psw", psw_o, 8'h85);
        chk("R7 brk nmi_clr", nmi_clr, 0);
        chk("R7 brk sp", sp_o, 16'h0200);

        // R8 pushes and pops
        run_op(OP_PUSH_PR, 0, 0, 0, 0, 0, 16'hBEEF, cyc);
        chk("R8 pair push cycles", cyc, 4);
        chk("R8 pair push wr", {wl_a[0], wl_d[0], wl_a[1], wl_d[1]}, {16'h01FF, 8'hBE, 16'h01FE, 8'hEF});
        chk("R8 pair push sp", sp_o, 16'h01FE);
        run_op(OP_PUSH_ST, 0, 0, 0, 0, 8'h5A, 0, cyc);
        chk("R8 st push cycles", cyc, 2);
        chk("R8 st push wr", {wl_a[0], wl_d[0]}, {16'h01FD, 8'h5A});
        chk("R8 st push sp", sp_o, 16'h01FD);
        run_op(OP_POP_ST, 0, 0, 0, 0, 0, 0, cyc);
        chk("R8 st pop cycles", cyc, 2);
        chk("R8 st pop psw", {psw_we, psw_o}, {1'b1, 8'h5A});
        chk("R8 st pop sp", sp_o, 16'h01FE);
        run_op(OP_POP_PR, 0, 0, 0, 0, 0, 0, cyc);
        chk("R8 pair pop cycles", cyc, 4);
        chk("R8 pair pop rp", {rp_we, rp_o}, {1'b1, 16'hBEEF});
        chk("R8 pair pop sp", sp_o, 16'h0200);

        // R9 SP read
        run_op(OP_SP_RD, 0, 0, 0, 0, 0, 0, cyc);
        chk("R9 sp read", {rp_we, pc_we, rp_o}, {1'b1, 1'b0, 16'h0200});

        // R12 start while busy is ignored
        @(negedge clk);
        wl_n = 0;
        op_i = OP_PUSH_ST; psw_i = 8'h11; start = 1'b1;
        @(negedge clk);
        op_i = OP_JMP_ABS; imm_i = 16'h9999; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (busy && cyc < 40) begin
            cyc++;
            @(negedge clk);
        end
        chk("R12 length of first op", cyc, 2);
        chk("R12 no pc load", pc_we, 0);
        chk("R12 write", {wl_n[3:0], wl_a[0], wl_d[0]}, {4'd1, 16'h01FF, 8'h11});
        chk("R12 sp", sp_o, 16'h01FF);
        @(negedge clk);
        chk("R12 second start dropped", {busy, done}, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule